// File: doc/BRIEF.md
# Hypervisor Extended Control Register

This block holds the extended hypervisor control word of a virtualization-capable processor model. It is a 64-bit register in which only five low bits carry meaning. Software writes it through a single-cycle write strobe. The block delivers two views of the contents. The first is the raw stored value, used for direct reads. The second is an effective value, which the trap and qualifier logic elsewhere in the core consume.

Feature straps decide which fields exist. A field that is absent stores nothing and reads as zero. Context inputs decide whether the control word applies at all: whether EL2 exists, whether EL2 is enabled in the current security state, whether EL3 exists, and the enable bit that EL3 owns. When the word does not apply, the effective value is zero, but a direct read still returns the stored bits.

Two asynchronous power-on reset clears everything. A synchronous warm reset clears the fields whose reset is defined. The storage side selects one update action each cycle: UPD_HOLD (no strobe), UPD_WRITE (strobe while EL2 exists) or UPD_WARM (warm reset, which wins over a write). The output side selects EFF_PASS when the context allows the word to apply and EFF_BLOCKED otherwise. Both selections are made again on every cycle, from the current inputs. Any action or mode may follow any other.

Top module: `hyp_ext_ctrl`

## Requirements
- R1: Bits 63 to 5 of the read value are always zero, and write data in those bits is discarded.
- R2: The field positions are fixed. Bit 4 is the fine-grained-trap nXS exemption, bit 3 forces nXS behaviour, bit 2 enables store-with-status, bit 1 enables 64-byte load/store, and bit 0 enables store-with-status-zero. Each written bit reads back at its own position.
- R3: When strap_xs is 0, bits 4 and 3 read as 0 and a write to them is discarded. Setting the strap later still reads 0 in those bits until a new write.
- R4: When strap_ls64 is 0, bits 2 to 0 read as 0 and a write to them is discarded. Setting the strap later still reads 0 in those bits until a new write.
- R5: A write sampled high at a rising clock edge shows on rd_value after that edge and not before. Without a write or a warm reset, the stored bits hold their value.
- R6: eff_value equals rd_value when el2_en_cur is 1 and either hi_enable is 1 or el3_present is 0. Otherwise eff_value is zero. rd_value is not affected by these inputs.
- R7: A warm reset always clears bits 4 and 3. It also clears bits 2 to 0 when el3_present is 0 and el2_present is 1; otherwise bits 2 to 0 keep their value. A warm reset takes priority over a write in the same cycle.
- R8: When el2_present is 0, rd_value and eff_value are zero and writes are discarded. The stored bits stay as they were.
- R9: While rst_n is low, all stored bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| strap_xs | input | 1 | XS feature present; enables bits 4 and 3 |
| strap_ls64 | input | 1 | 64-byte load/store feature present; enables bits 2 to 0 |
| el2_present | input | 1 | EL2 is implemented |
| el3_present | input | 1 | EL3 is implemented |
| el2_en_cur | input | 1 | EL2 is enabled in the current security state |
| hi_enable | input | 1 | Enable bit owned by EL3 |
| rd_value | output | 64 | Stored value for direct reads |
| eff_value | output | 64 | Effective value for trap and qualifier logic |

## Verification
The assertions check on every cycle that:
- the reserved and absent bits are zero;
- eff_value is zero or equals rd_value, according to the context;
- EL2 absence forces both outputs to zero;
- a write or a warm reset lands on the following edge.

Only the bench scenarios can show the following:
- bits discarded under a cleared strap stay zero once the strap is later set;
- stored bits survive a period with EL2 absent;
- bits 2 to 0 survive a warm reset when EL3 is present;
- the read value does not change in the same cycle as the strobe.

// File: rtl/hxc_pkg.sv
`timescale 1ns/1ps
package hxc_pkg;
    localparam int REG_W   = 64;
    localparam int FLD_W   = 5;
    localparam int LS_BITS = 3;

    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_WARM,
        UPD_WRITE
    } upd_e;

    typedef enum logic {
        EFF_BLOCKED,
        EFF_PASS
    } eff_mode_e;
endpackage

// File: rtl/hxc_field_mask.sv
`timescale 1ns/1ps
module hxc_field_mask #(
    parameter int REG_W   = 64,
    parameter int FLD_W   = 5,
    parameter int LS_BITS = 3
) (
    input  logic             strap_xs,
    input  logic             strap_ls64,
    output logic [REG_W-1:0] fld_mask,
    output logic [REG_W-1:0] warm_keep_hi
);
    for (genvar g = 0; g < REG_W; g++) begin : g_bit
        if (g < LS_BITS) begin : g_ls
            assign fld_mask[g]     = strap_ls64;
            assign warm_keep_hi[g] = 1'b1;
        end else if (g < FLD_W) begin : g_xs
            assign fld_mask[g]     = strap_xs;
            assign warm_keep_hi[g] = 1'b0;
        end else begin : g_rsv
            assign fld_mask[g]     = 1'b0;
            assign warm_keep_hi[g] = 1'b0;
        end
    end
endmodule

// File: rtl/hxc_store.sv
`timescale 1ns/1ps
module hxc_store
    import hxc_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_rst,
    input  logic             wr_en,
    input  logic             el2_present,
    input  logic             el3_present,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] fld_mask,
    input  logic [REG_W-1:0] warm_keep_hi,
    output logic [REG_W-1:0] q
);
    upd_e             upd;
    logic [REG_W-1:0] warm_keep;
    logic             clr_low;

    assign clr_low = el2_present & ~el3_present;

    always_comb begin
        warm_keep = warm_keep_hi & {REG_W{~clr_low}};
        if (warm_rst) begin
            upd = UPD_WARM;
        end else if (wr_en && el2_present) begin
            upd = UPD_WRITE;
        end else begin
            upd = UPD_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (upd)
                UPD_WARM:  q <= q & warm_keep;
                UPD_WRITE: q <= wr_data & fld_mask;
                default:   q <= q;
            endcase
        end
    end

    // R7: a warm reset always clears the upper field pair
    p_warm_hi_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> (q[REG_W-1:3] == '0));

    // R5: stored bits hold when nothing updates them
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!warm_rst && !(wr_en && el2_present)) |=> $stable(q));
endmodule

// File: rtl/hxc_gate.sv
`timescale 1ns/1ps
module hxc_gate
    import hxc_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic             el2_en_cur,
    input  logic             hi_enable,
    input  logic             el3_present,
    input  logic [REG_W-1:0] raw,
    output logic [REG_W-1:0] eff
);
    eff_mode_e mode;

    always_comb begin
        if (el2_en_cur && (hi_enable || !el3_present)) begin
            mode = EFF_PASS;
        end else begin
            mode = EFF_BLOCKED;
        end
    end

    always_comb begin
        unique case (mode)
            EFF_PASS: eff = raw;
            default:  eff = '0;
        endcase
    end
endmodule

// File: rtl/hyp_ext_ctrl.sv
`timescale 1ns/1ps
module hyp_ext_ctrl
    import hxc_pkg::*;
#(
    parameter int REG_W   = hxc_pkg::REG_W,
    parameter int FLD_W   = hxc_pkg::FLD_W,
    parameter int LS_BITS = hxc_pkg::LS_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             strap_xs,
    input  logic             strap_ls64,
    input  logic             el2_present,
    input  logic             el3_present,
    input  logic             el2_en_cur,
    input  logic             hi_enable,
    output logic [REG_W-1:0] rd_value,
    output logic [REG_W-1:0] eff_value
);
    logic [REG_W-1:0] fld_mask;
    logic [REG_W-1:0] warm_keep_hi;
    logic [REG_W-1:0] q;

    hxc_field_mask #(.REG_W(REG_W), .FLD_W(FLD_W), .LS_BITS(LS_BITS)) i_mask (
        .strap_xs    (strap_xs),
        .strap_ls64  (strap_ls64),
        .fld_mask    (fld_mask),
        .warm_keep_hi(warm_keep_hi)
    );

    hxc_store #(.REG_W(REG_W)) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .warm_rst    (warm_rst),
        .wr_en       (wr_en),
        .el2_present (el2_present),
        .el3_present (el3_present),
        .wr_data     (wr_data),
        .fld_mask    (fld_mask),
        .warm_keep_hi(warm_keep_hi),
        .q           (q)
    );

    assign rd_value = el2_present ? (q & fld_mask) : '0;

    hxc_gate #(.REG_W(REG_W)) i_gate (
        .el2_en_cur (el2_en_cur),
        .hi_enable  (hi_enable),
        .el3_present(el3_present),
        .raw        (rd_value),
        .eff        (eff_value)
    );

    // R1: reserved bits never read as one
    p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_value[REG_W-1:FLD_W] == '0);

    // R3: absent XS fields read zero
    p_xs_absent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_xs |-> (rd_value[FLD_W-1:LS_BITS] == '0));

    // R4: absent 64-byte fields read zero
    p_ls_absent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_ls64 |-> (rd_value[LS_BITS-1:0] == '0));

    // R5: a write lands on the following edge
    p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !warm_rst && el2_present) |=>
        (!$stable({strap_xs, strap_ls64, el2_present}) ||
         rd_value == ($past(wr_data) & fld_mask)));

    // R6: suppressed context gives a zero effective value
    p_eff_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(el2_en_cur && (hi_enable || !el3_present)) |-> (eff_value == '0));

    // R6: permitted context passes the read value through
    p_eff_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (el2_en_cur && (hi_enable || !el3_present)) |-> (eff_value == rd_value));

    // R7: warm reset without EL3 clears the low fields
    p_warm_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst && !el3_present && el2_present) |=> (rd_value[LS_BITS-1:0] == '0));

    // R8: EL2 absent forces both views to zero
    p_no_el2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !el2_present |-> (rd_value == '0 && eff_value == '0));
endmodule

// File: tb/test_hyp_ext_ctrl.sv
`timescale 1ns/1ps
module test_hyp_ext_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        strap_xs = 1'b1;
    logic        strap_ls64 = 1'b1;
    logic        el2_present = 1'b1;
    logic        el3_present = 1'b1;
    logic        el2_en_cur = 1'b1;
    logic        hi_enable = 1'b1;
    logic [63:0] rd_value;
    logic [63:0] eff_value;

    int n_chk = 0;
    int n_fail = 0;
    logic [4:0] m_q = '0;

    always #4 clk = ~clk;

    hyp_ext_ctrl i_hyp_ext_ctrl (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .wr_en(wr_en),
        .wr_data(wr_data), .strap_xs(strap_xs), .strap_ls64(strap_ls64),
        .el2_present(el2_present), .el3_present(el3_present),
        .el2_en_cur(el2_en_cur), .hi_enable(hi_enable),
        .rd_value(rd_value), .eff_value(eff_value)
    );

    function automatic logic [4:0] exp_mask();
        return {strap_xs, strap_xs, strap_ls64, strap_ls64, strap_ls64};
    endfunction

    function automatic logic [63:0] exp_rd();
        return el2_present ? {59'b0, m_q & exp_mask()} : 64'b0;
    endfunction

    function automatic logic [63:0] exp_eff();
        return (el2_en_cur && (hi_enable || !el3_present)) ? exp_rd() : 64'b0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag, input logic wr, input logic [63:0] wd, input logic warm);
        wr_en = wr;
        wr_data = wd;
        warm_rst = warm;
        @(posedge clk);
        if (warm) begin
            m_q[4:3] = 2'b0;
            if (!el3_present && el2_present) m_q[2:0] = 3'b0;
        end else if (wr && el2_present) begin
            m_q = wd[4:0] & exp_mask();
        end
        @(negedge clk);
        wr_en = 1'b0;
        warm_rst = 1'b0;
        chk({tag, " read"}, rd_value, exp_rd());
        chk({tag, " effective"}, eff_value, exp_eff());
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        chk("R9 reset read", rd_value, 64'h0);
        chk("R9 reset effective", eff_value, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        cyc("R2", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        chk("R1 all ones", rd_value, 64'h1F);
        for (int i = 0; i < 5; i++) begin
            cyc("R2", 1'b1, 64'h1 << i, 1'b0);
            chk("R2 walking bit", rd_value, 64'h1 << i);
        end
        cyc("R1", 1'b1, 64'h0000_0100_0000_0020, 1'b0);
        chk("R1 reserved write", rd_value, 64'h0);

        // R5 same-cycle stability, then landing after the edge
        wr_en = 1'b1;
        wr_data = 64'h15;
        #1;
        chk("R5 before edge", rd_value, 64'h0);
        cyc("R5", 1'b1, 64'h15, 1'b0);
        chk("R5 after edge", rd_value, 64'h15);
        cyc("R5 hold", 1'b0, 64'h0A, 1'b0);
        chk("R5 held", rd_value, 64'h15);

        // R6 context gating
        hi_enable = 1'b0;
        cyc("R6", 1'b0, 64'h0, 1'b0);
        chk("R6 blocked eff", eff_value, 64'h0);
        chk("R6 raw kept", rd_value, 64'h15);
        el3_present = 1'b0;
        cyc("R6", 1'b0, 64'h0, 1'b0);
        chk("R6 no el3 passes", eff_value, 64'h15);
        el2_en_cur = 1'b0;
        cyc("R6", 1'b0, 64'h0, 1'b0);
        chk("R6 el2 off", eff_value, 64'h0);
        el2_en_cur = 1'b1;
        hi_enable = 1'b1;
        el3_present = 1'b1;

        // R3 and R4 straps
        strap_xs = 1'b0;
        cyc("R3", 1'b1, 64'h1F, 1'b0);
        chk("R3 xs absent", rd_value, 64'h07);
        strap_xs = 1'b1;
        @(negedge clk);
        chk("R3 xs later set", rd_value, 64'h07);
        strap_ls64 = 1'b0;
        cyc("R4", 1'b1, 64'h1F, 1'b0);
        chk("R4 ls absent", rd_value, 64'h18);
        strap_ls64 = 1'b1;
        @(negedge clk);
        chk("R4 ls later set", rd_value, 64'h18);

        // R7 warm reset
        cyc("R7", 1'b1, 64'h1F, 1'b0);
        cyc("R7", 1'b0, 64'h0, 1'b1);
        chk("R7 warm with el3", rd_value, 64'h07);
        el3_present = 1'b0;
        cyc("R7", 1'b0, 64'h0, 1'b1);
        chk("R7 warm without el3", rd_value, 64'h0);
        cyc("R7", 1'b1, 64'h1F, 1'b1);
        chk("R7 warm beats write", rd_value, 64'h0);
        el3_present = 1'b1;

        // R8 EL2 absent
        cyc("R8", 1'b1, 64'h0B, 1'b0);
        el2_present = 1'b0;
        cyc("R8", 1'b1, 64'h1F, 1'b0);
        chk("R8 read zero", rd_value, 64'h0);
        chk("R8 eff zero", eff_value, 64'h0);
        el2_present = 1'b1;
        @(negedge clk);
        chk("R8 contents kept", rd_value, 64'h0B);

        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            strap_xs    = (r[3:0] != 0);
            strap_ls64  = (r[7:4] != 0);
            el2_present = (r[11:8] != 0);
            el3_present = r[12];
            el2_en_cur  = (r[14:13] != 0);
            hi_enable   = (r[16:15] != 0);
            cyc("R5 random", r[17] | r[18], {$urandom, $urandom}, (r[22:19] == 0));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule